// File: doc/BRIEF.md
# Low-Side Switch Fault Latch Controller

This block keeps the digital fault state for a group of low-side switch channels (four by default). Each channel receives an on/off command and two digital sense indications, one for overheating and one for an open (high-impedance) load. The block turns each command into a gate enable and keeps two sticky flags per channel. A diagnostic shift register and an interrupt generator elsewhere on the chip read those flags through one flat vector.

All command and sense inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser. A registered compare on the synchronised command gives one-cycle rising and falling edge pulses. Each channel runs a three-state machine. `CH_IDLE` means the gate is off by command. `CH_DRIVE` means the gate is on. `CH_TRIP` is the thermal shutdown latch. The transitions are:

- **heat trip**: from `CH_IDLE` or `CH_DRIVE` to `CH_TRIP` whenever overheating is sensed.
- **switch on**: from `CH_IDLE` to `CH_DRIVE` when the command is high.
- **switch off**: from `CH_DRIVE` to `CH_IDLE` when the command is low.
- **re-arm**: from `CH_TRIP` to `CH_DRIVE` on a command rising edge with no overheating sensed.
- **re-trip**: from `CH_TRIP` back to `CH_TRIP` on a command rising edge while overheating persists.

The open-load flag is a separate register. It never acts on the gate. A low supply-good input, or a low active-low reset, holds every gate off.

Top module: `lowside_fault_keeper`

## Requirements
- R1: When channel i senses overheating, its thermal flag `fault_flags[i]` becomes 1 and `gate_en[i]` becomes 0, whatever its command level. The latency is three clock edges from the sense input.
- R2: Once tripped, a channel keeps its thermal flag at 1 and its gate at 0 after the overheating indication goes away, for as long as no command rising edge occurs. A steady high command does not release it.
- R3: A command rising edge on a tripped channel with no overheating sensed clears the thermal flag and turns the gate on, three edges after the command rises.
- R4: A command rising edge on a tripped channel while overheating is still sensed leaves the thermal flag at 1 and the gate at 0.
- R5: The open-load flag of channel i is `fault_flags[NCH+i]`. It is set only when an open load is sensed while the synchronised command is low. An open-load indication while the command is high has no effect.
- R6: The open-load flag clears in the cycle after a command falling edge. If an open load is still sensed then, the clear wins for that cycle and the flag returns one edge later.
- R7: The open-load flag never changes a gate enable. A channel with the flag set still switches on and off with its command.
- R8: Without a trip, `gate_en[i]` follows the command with a latency of three clock edges. Channels are independent of one another.
- R9: A low `supply_ok` forces all gate enables to 0 at the next clock edge. Flags and channel states are kept, and the gates return one edge after `supply_ok` goes high again.
- R10: While `rst_n` is low, all flags are 0 and all gate enables are 0. Assertion of `rst_n` acts without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Logic supply good; low disables all gates |
| chan_cmd | input | NCH | Per-channel on/off command (asynchronous) |
| ot_sense | input | NCH | Per-channel overheating indication (asynchronous) |
| ol_sense | input | NCH | Per-channel open-load indication (asynchronous) |
| gate_en | output | NCH | Per-channel gate enable |
| fault_flags | output | 2*NCH | Thermal flags in bits NCH-1..0, open-load flags in bits 2*NCH-1..NCH |

## Verification
Two functions can land in one cycle and ask opposite things of the same flag.

The first collision is the open-load clear and the open-load set. The bench holds the open-load sense high while a command falls. It then checks that the flag reads 0 exactly three edges after the fall and 1 one edge later.

The second collision is the re-arm and the heat trip. A command rising edge arrives while overheating is still sensed, and the bench requires the thermal flag to stay set and the gate to stay off. Only a later rising edge, after the sense has cleared, may release the channel.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_DRIVE = 2'd1,
        CH_TRIP  = 2'd2
    } ch_state_e;

endpackage

// File: rtl/lsf_sync.sv
module lsf_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    // Stage 0 takes the raw input; each later stage copies the one before it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe[s] <= '0;
            end
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/lsf_edge.sv
module lsf_edge #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    logic [W-1:0] lvl_d;

    // One-cycle delayed copy of the level, compared against the current level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_d <= '0;
        end else begin
            lvl_d <= lvl;
        end
    end

    assign rise = lvl & ~lvl_d;
    assign fall = ~lvl & lvl_d;

endmodule

// File: rtl/lsf_chan.sv
module lsf_chan
    import lsf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok,
    input  logic cmd_lvl,
    input  logic cmd_rise,
    input  logic cmd_fall,
    input  logic ot_lvl,
    input  logic ol_lvl,
    output logic gate_en,
    output logic ot_flag,
    output logic ol_flag
);

    ch_state_e state, state_n;
    logic      gate_q;
    logic      ol_q;

    // Next-state logic.
    always_comb begin
        state_n = state;
        unique case (state)
            CH_IDLE: begin
                if (ot_lvl) begin
                    state_n = CH_TRIP;          // heat trip
                end else if (cmd_lvl) begin
                    state_n = CH_DRIVE;         // switch on
                end
            end
            CH_DRIVE: begin
                if (ot_lvl) begin
                    state_n = CH_TRIP;          // heat trip
                end else if (!cmd_lvl) begin
                    state_n = CH_IDLE;          // switch off
                end
            end
            CH_TRIP: begin
                if (cmd_rise && !ot_lvl) begin
                    state_n = CH_DRIVE;         // re-arm
                end                             // else hold or re-trip
            end
            default: state_n = CH_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Output register: gate enable and open-load flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            ol_q   <= 1'b0;
        end else begin
            gate_q <= (state_n == CH_DRIVE) && pwr_ok;
            if (cmd_fall) begin
                ol_q <= 1'b0;
            end else if (ol_lvl && !cmd_lvl) begin
                ol_q <= 1'b1;
            end
        end
    end

    assign gate_en = gate_q;
    assign ot_flag = (state == CH_TRIP);
    assign ol_flag = ol_q;

    // R1: an overheating indication always leads to the trip state.
    a_r1_heat_trips: assert property (@(posedge clk) disable iff (!rst_n)
        ot_lvl |=> (state == CH_TRIP));

    // R2: a tripped channel never drives its gate.
    a_r2_trip_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_TRIP) |-> !gate_q);

    // R2: without a rising command edge the trip latch holds.
    a_r2_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CH_TRIP) && !cmd_rise) |=> (state == CH_TRIP));

    // R4: a rising edge during persisting overheating does not release.
    a_r4_retrip: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == CH_TRIP) && ot_lvl) |=> (state == CH_TRIP));

    // R5: the open-load flag only rises after a cycle with the command off.
    a_r5_ol_set_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ol_q) |-> $past(!cmd_lvl));

    // R6: a falling command edge clears the open-load flag.
    a_r6_ol_clear_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fall |=> !ol_q);

    // R9: a low supply turns the gate off at the next edge.
    a_r9_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |=> !gate_q);

endmodule

// File: rtl/lowside_fault_keeper.sv
module lowside_fault_keeper #(
    parameter int NCH         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             supply_ok,
    input  logic [NCH-1:0]   chan_cmd,
    input  logic [NCH-1:0]   ot_sense,
    input  logic [NCH-1:0]   ol_sense,
    output logic [NCH-1:0]   gate_en,
    output logic [2*NCH-1:0] fault_flags
);

    localparam int FLAG_W = 2 * NCH;

    logic [NCH-1:0]    cmd_s, ot_s, ol_s;
    logic [NCH-1:0]    cmd_rise, cmd_fall;
    logic [NCH-1:0]    ot_flag, ol_flag;
    logic [FLAG_W-1:0] flags_w;

    lsf_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_cmd (
        .clk(clk), .rst_n(rst_n), .d(chan_cmd), .q(cmd_s)
    );
    lsf_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_ot (
        .clk(clk), .rst_n(rst_n), .d(ot_sense), .q(ot_s)
    );
    lsf_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_ol (
        .clk(clk), .rst_n(rst_n), .d(ol_sense), .q(ol_s)
    );

    lsf_edge #(.W(NCH)) u_cmd_edge (
        .clk(clk), .rst_n(rst_n), .lvl(cmd_s), .rise(cmd_rise), .fall(cmd_fall)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        lsf_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .pwr_ok   (supply_ok),
            .cmd_lvl  (cmd_s[i]),
            .cmd_rise (cmd_rise[i]),
            .cmd_fall (cmd_fall[i]),
            .ot_lvl   (ot_s[i]),
            .ol_lvl   (ol_s[i]),
            .gate_en  (gate_en[i]),
            .ot_flag  (ot_flag[i]),
            .ol_flag  (ol_flag[i])
        );
    end

    // Thermal flags in the low half, open-load flags in the high half.
    assign flags_w     = {ol_flag, ot_flag};
    assign fault_flags = flags_w;

    // R9: a low supply leaves every gate off one edge later.
    a_r9_all_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (gate_en == '0));

    // R7: a set open-load flag never holds a gate off while its command stays high.
    a_r7_ol_no_block: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && ot_flag == '0 && ot_s == '0 && $stable(cmd_s) && $stable(supply_ok))
            |-> (gate_en == cmd_s));

endmodule

// File: tb/lowside_fault_keeper_test.sv
module lowside_fault_keeper_test;

    localparam int NCH = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             supply_ok;
    logic [NCH-1:0]   chan_cmd;
    logic [NCH-1:0]   ot_sense;
    logic [NCH-1:0]   ol_sense;
    logic [NCH-1:0]   gate_en;
    logic [2*NCH-1:0] fault_flags;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    lowside_fault_keeper #(.NCH(NCH), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
        .chan_cmd(chan_cmd), .ot_sense(ot_sense), .ol_sense(ol_sense),
        .gate_en(gate_en), .fault_flags(fault_flags)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // R10: reset state
    task automatic t_reset;
        rst_n = 1'b0; supply_ok = 1'b1;
        chan_cmd = '0; ot_sense = '0; ol_sense = '0;
        step(3);
        chk("R10 gates in reset", int'(gate_en), 0);
        chk("R10 flags in reset", int'(fault_flags), 0);
        rst_n = 1'b1;
        step(2);
    endtask

    // R8: gate follows the command with three edges of latency
    task automatic t_follow;
        chan_cmd = 4'b0101;
        step(2);
        chk("R8 gate before latency", int'(gate_en), 0);
        step(1);
        chk("R8 gate follows", int'(gate_en), 'h5);
        chan_cmd = 4'b1010;
        step(3);
        chk("R8 second pattern", int'(gate_en), 'hA);
        chan_cmd = '0;
        step(3);
        chk("R8 gate off", int'(gate_en), 0);
    endtask

    // R1, R2, R3: trip with command low, release on a rising edge
    task automatic t_ot_low_cmd;
        ot_sense[1] = 1'b1;
        step(3);
        chk("R1 thermal flag set with cmd low", int'(fault_flags[1]), 1);
        chk("R1 gate off", int'(gate_en[1]), 0);
        ot_sense[1] = 1'b0;
        step(3);
        chk("R2 flag held after sense clears", int'(fault_flags[1]), 1);
        chan_cmd[1] = 1'b1;
        step(3);
        chk("R3 flag cleared on rise", int'(fault_flags[1]), 0);
        chk("R3 gate on after re-arm", int'(gate_en[1]), 1);
        chan_cmd[1] = 1'b0;
        step(3);
    endtask

    // R1, R2, R4, R11-style independence covered by R8
    task automatic t_ot_high_cmd;
        chan_cmd = 4'b1111;
        step(3);
        chk("R8 all gates on", int'(gate_en), 'hF);
        ot_sense[2] = 1'b1;
        step(3);
        chk("R1 gate 2 dropped, others on", int'(gate_en), 'hB);
        chk("R1 thermal flag 2", int'(fault_flags), 'h04);
        ot_sense[2] = 1'b0;
        step(5);
        chk("R2 high cmd does not release", int'(gate_en), 'hB);
        chan_cmd[2] = 1'b0;
        step(3);
        ot_sense[2] = 1'b1;
        step(3);
        chan_cmd[2] = 1'b1;
        step(3);
        chk("R4 rise with heat keeps flag", int'(fault_flags[2]), 1);
        chk("R4 rise with heat keeps gate off", int'(gate_en[2]), 0);
        ot_sense[2] = 1'b0;
        step(3);
        chk("R2 still tripped", int'(fault_flags[2]), 1);
        chan_cmd[2] = 1'b0;
        step(3);
        chan_cmd[2] = 1'b1;
        step(3);
        chk("R3 released", int'(gate_en), 'hF);
        chk("R3 flags clear", int'(fault_flags), 0);
        chan_cmd = '0;
        step(3);
    endtask

    // R5, R6, R7: open-load flag behaviour
    task automatic t_open_load;
        chan_cmd[0] = 1'b1;
        step(3);
        ol_sense[0] = 1'b1;
        step(5);
        chk("R5 open load ignored while on", int'(fault_flags[4]), 0);
        chk("R7 gate unaffected", int'(gate_en[0]), 1);
        ol_sense[0] = 1'b0;
        chan_cmd[0] = 1'b0;
        step(3);
        ol_sense[0] = 1'b1;
        step(3);
        chk("R5 open load set while off", int'(fault_flags[4]), 1);
        ol_sense[0] = 1'b0;
        step(2);
        chan_cmd[0] = 1'b1;
        step(3);
        chk("R7 gate on with open-load flag", int'(gate_en[0]), 1);
        chk("R6 flag kept across rise", int'(fault_flags[4]), 1);
        chan_cmd[0] = 1'b0;
        step(3);
        chk("R6 flag cleared on fall", int'(fault_flags[4]), 0);
        chan_cmd[0] = 1'b1;
        step(3);
        ol_sense[0] = 1'b1;
        step(3);
        chan_cmd[0] = 1'b0;
        step(3);
        chk("R6 clear wins on fall cycle", int'(fault_flags[4]), 0);
        step(1);
        chk("R6 flag returns next edge", int'(fault_flags[4]), 1);
        ol_sense[0] = 1'b0;
        step(3);
    endtask

    // R9: supply-good gating
    task automatic t_supply;
        chan_cmd = 4'b0111;
        ol_sense[3] = 1'b1;
        step(3);
        ol_sense[3] = 1'b0;
        chk("R9 setup gates", int'(gate_en), 'h7);
        supply_ok = 1'b0;
        step(1);
        chk("R9 gates off on low supply", int'(gate_en), 0);
        chk("R9 flags kept", int'(fault_flags[7]), 1);
        supply_ok = 1'b1;
        step(1);
        chk("R9 gates return", int'(gate_en), 'h7);
    endtask

    // R10: reset in mid-run clears flags and gates at once
    task automatic t_reset_mid;
        ot_sense[0] = 1'b1;
        step(3);
        chk("R10 setup trip", int'(fault_flags[0]), 1);
        @(posedge clk);
        #2 rst_n = 1'b0;
        #1;
        chk("R10 async gate clear", int'(gate_en), 0);
        chk("R10 async flag clear", int'(fault_flags), 0);
        ot_sense[0] = 1'b0;
        step(2);
        chk("R10 held in reset", int'(gate_en), 0);
        rst_n = 1'b1;
        step(4);
        chk("R10 recovery after reset", int'(gate_en), 'h7);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        rst_n = 1'b0; supply_ok = 1'b1;
        chan_cmd = '0; ot_sense = '0; ol_sense = '0;
        @(negedge clk);
        t_reset();
        t_follow();
        t_ot_low_cmd();
        t_ot_high_cmd();
        t_open_load();
        t_supply();
        t_reset_mid();
        report();
    end

endmodule